// File: doc/BRIEF.md
# Marker-Bit UART Transmitter

This block serialises one byte at a time into a 10-bit asynchronous frame: a low start bit, the eight data bits least significant first, then a high stop bit. Software hands it a byte through a one-cycle write strobe. The line output rests high between frames. A sticky completion flag rises once the stop bit has been fully sent, and stays up until a clear pulse.

Bit timing comes from an overflow pulse supplied by an external timer. A mode input chooses whether every overflow pulse is used, or only every second one. The resulting ticks drive a free-running modulo-16 counter, and one bit lasts one full turn of that counter. The write does not restart the counter. Every frame therefore starts, and every bit edge falls, on a counter rollover.

No bit counter tracks the frame. A written byte enters a 9-bit shift register with a 1 above it in the top position. Zeros fill in from the top as the register shifts. The data phase ends when a shift leaves that 1 alone in the lowest position.

Top module: `uart_marker_tx`

## Requirements
- R1: A frame on `txd` is a 0 start bit, then data bits 0 through 7 in that order, then a 1 stop bit. Each bit lasts exactly 16 counted ticks, measured from one counter rollover to the next.
- R2: `txd` is high whenever no frame is on the line. It changes only on the clock edge at which a rollover (the 16th counted tick of a turn) is seen.
- R3: The start bit appears on the clock edge of the first rollover after the edge that accepted the write. The write itself never resets the tick counter.
- R4: The data phase always carries exactly eight bits, for any byte value including 0x00 and 0xFF.
- R5: An accepted write loads the byte into the low eight bits of the shift register and a 1 into bit 8. While data bits are being sent, the register is never all zeros.
- R6: When `no_halve` is 1, every `tmr_ovf` pulse is a counted tick. When it is 0, only the 2nd, 4th, 6th and later pulses after reset are counted (pulses are numbered from reset in either mode).
- R7: `tx_done` rises on the rollover that ends the stop bit and is low during the frame. It then holds high until a cycle with `done_clr` high, after which it reads 0.
- R8: A write that arrives while a frame is pending or on the line is dropped. It changes neither the bits of that frame nor starts a second frame.
- R9: While reset is held, `txd` is 1 and `tx_done` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tmr_ovf | input | 1 | One-cycle timer overflow pulse |
| no_halve | input | 1 | 1: count every overflow; 0: count every second overflow |
| wr_stb | input | 1 | One-cycle write strobe for `wr_byte` |
| wr_byte | input | 8 | Byte to transmit |
| done_clr | input | 1 | Clears the completion flag |
| txd | output | 1 | Serial line output |
| tx_done | output | 1 | Sticky frame-complete flag |

## Verification
The hardest behaviour to reach from the ports is how the start bit lines up with a rollover of a counter that the write does not touch. A bench that always writes at the same phase would only ever exercise one latency. The stimulus therefore waits a random number of cycles before each write and uses randomly spaced overflow pulses. This places writes at many counter phases, including writes just before a rollover. A reference count of ticks and rollovers kept in the bench sets every mid-bit sample point and the expected start edge. The bench also injects writes in the middle of frames in both prescale modes.

// File: rtl/umtx_pkg.sv
package umtx_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_WAIT,
    PH_SEND,
    PH_DATA,
    PH_STOP
  } phase_t;
endpackage

// File: rtl/umtx_baud.sv
module umtx_baud #(
  parameter int OS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ovf,
  input  logic no_halve,
  output logic tick,
  output logic roll
);
  localparam int CW = $clog2(OS);
  localparam logic [CW-1:0] LAST = CW'(OS - 1);

  logic          half_q;
  logic [CW-1:0] cnt_q;

  assign tick = ovf & (no_halve | half_q);
  assign roll = tick & (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (ovf) half_q <= ~half_q;
      if (tick) cnt_q <= roll ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/umtx_shifter.sv
module umtx_shifter #(
  parameter int DW = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic        shift,
  input  logic        clear,
  input  logic [DW-1:0] din,
  output logic [DW:0] sreg,
  output logic        lsb,
  output logic        marker_next
);
  localparam logic [DW:0] ONLY_MARK = (DW + 1)'(1);

  function automatic logic [DW:0] shr(input logic [DW:0] v);
    return {1'b0, v[DW:1]};
  endfunction

  assign lsb         = sreg[0];
  assign marker_next = (shr(sreg) == ONLY_MARK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sreg <= '0;
    else if (load)  sreg <= {1'b1, din};
    else if (shift) sreg <= shr(sreg);
    else if (clear) sreg <= '0;
  end
endmodule

// File: rtl/umtx_seq.sv
module umtx_seq
  import umtx_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   wr_stb,
  input  logic   roll,
  input  logic   marker_next,
  input  logic   done_clr,
  output phase_t phase,
  output logic   load,
  output logic   shift,
  output logic   clear,
  output logic   done_set,
  output logic   done_q
);
  phase_t nxt;

  assign load     = wr_stb && (phase == PH_IDLE);
  assign shift    = roll && (phase == PH_DATA);
  assign done_set = roll && (phase == PH_STOP);
  assign clear    = done_set;

  always_comb begin
    nxt = phase;
    unique case (phase)
      PH_IDLE: if (load) nxt = PH_WAIT;
      PH_WAIT: if (roll) nxt = PH_SEND;
      PH_SEND: if (roll) nxt = PH_DATA;
      PH_DATA: if (roll && marker_next) nxt = PH_STOP;
      PH_STOP: if (roll) nxt = PH_IDLE;
      default: nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      done_q <= 1'b0;
    end else begin
      phase <= nxt;
      if (done_set)      done_q <= 1'b1;
      else if (done_clr) done_q <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_marker_tx.sv
module uart_marker_tx
  import umtx_pkg::*;
#(
  parameter int DW = 8,
  parameter int OS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tmr_ovf,
  input  logic          no_halve,
  input  logic          wr_stb,
  input  logic [DW-1:0] wr_byte,
  input  logic          done_clr,
  output logic          txd,
  output logic          tx_done
);
  logic        tick_w, roll_w;
  logic        load_w, shift_w, clear_w, done_set_w;
  logic        lsb_w, marker_next_w;
  logic [DW:0] sreg_w;
  phase_t      phase_w;
  logic        busy_w, in_data_w;

  umtx_baud #(.OS(OS)) u_baud (
    .clk(clk), .rst_n(rst_n), .ovf(tmr_ovf), .no_halve(no_halve),
    .tick(tick_w), .roll(roll_w)
  );

  umtx_shifter #(.DW(DW)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(load_w), .shift(shift_w),
    .clear(clear_w), .din(wr_byte), .sreg(sreg_w), .lsb(lsb_w),
    .marker_next(marker_next_w)
  );

  umtx_seq u_seq (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .roll(roll_w),
    .marker_next(marker_next_w), .done_clr(done_clr), .phase(phase_w),
    .load(load_w), .shift(shift_w), .clear(clear_w),
    .done_set(done_set_w), .done_q(tx_done)
  );

  assign busy_w    = (phase_w != PH_IDLE);
  assign in_data_w = (phase_w == PH_DATA);

  always_comb begin
    unique case (phase_w)
      PH_SEND: txd = 1'b0;
      PH_DATA: txd = lsb_w;
      default: txd = 1'b1;
    endcase
  end
endmodule

// File: rtl/umtx_checker.sv
module umtx_checker #(
  parameter int DW = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic        tmr_ovf,
  input logic        wr_stb,
  input logic        done_clr,
  input logic        txd,
  input logic        tx_done,
  input logic        tick,
  input logic        roll,
  input logic        busy,
  input logic        in_data,
  input logic        done_set,
  input logic [DW:0] sreg
);
  AST_TXD_ONLY_ON_ROLL: assert property (@(posedge clk) disable iff (!rst_n)
    !roll |=> $stable(txd)); // R2
  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd); // R2
  AST_START_AFTER_ROLL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(txd) |-> $past(roll)); // R3
  AST_MARKER_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
    in_data |-> (sreg != '0)); // R5
  AST_TICK_NEEDS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> tmr_ovf); // R6
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done && !done_clr |=> tx_done); // R7
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    done_clr && !done_set |=> !tx_done); // R7
  AST_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb && busy && !roll |=> $stable(sreg)); // R8
endmodule

bind uart_marker_tx umtx_checker #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tmr_ovf(tmr_ovf), .wr_stb(wr_stb),
  .done_clr(done_clr), .txd(txd), .tx_done(tx_done), .tick(tick_w),
  .roll(roll_w), .busy(busy_w), .in_data(in_data_w),
  .done_set(done_set_w), .sreg(sreg_w)
);

// File: tb/uart_marker_tx_test.sv
module uart_marker_tx_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tmr_ovf = 1'b0;
  logic       no_halve = 1'b1;
  logic       wr_stb = 1'b0;
  logic [7:0] wr_byte = 8'h00;
  logic       done_clr = 1'b0;
  logic       txd, tx_done;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  int par = 0, mcnt = 0;
  bit last_tick, last_roll;

  always #10 clk = ~clk;

  uart_marker_tx uut (
    .clk(clk), .rst_n(rst_n), .tmr_ovf(tmr_ovf), .no_halve(no_halve),
    .wr_stb(wr_stb), .wr_byte(wr_byte), .done_clr(done_clr),
    .txd(txd), .tx_done(tx_done)
  );

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  function automatic bit exp_bit(logic [7:0] d, int idx);
    if (idx == 0) return 1'b0;
    if (idx == 9) return 1'b1;
    return d[idx-1];
  endfunction

  // One clock: random overflow, then reference tick/rollover bookkeeping (R6).
  task automatic step();
    tmr_ovf = rst_n && ($urandom % 2 == 0);
    @(posedge clk);
    cyc++;
    last_tick = 0;
    last_roll = 0;
    if (tmr_ovf) begin
      par++;
      if (no_halve || (par % 2 == 0)) begin
        last_tick = 1;
        last_roll = (mcnt == 15);
        mcnt = (mcnt + 1) % 16;
      end
    end
    #1;
    wr_stb = 1'b0;
    done_clr = 1'b0;
  endtask

  task automatic send_frame(logic [7:0] d, bit inject, int gap);
    int rolls = 0;
    int guard;
    bit started = 0;
    bit mid_ok;
    bit second;
    for (int i = 0; i < gap; i++) step();
    wr_byte = d;
    wr_stb = 1'b1;
    step();
    guard = 0;
    while (!started && guard < 4000) begin
      step();
      if (last_roll) rolls++;
      if (txd == 1'b0) started = 1;
      guard++;
    end
    chk("R3 start on rollover edge", started && last_roll, 1);
    chk("R3 first rollover after write", rolls, 1);
    for (int b = 0; b < 10; b++) begin
      mid_ok = 0;
      guard = 0;
      while (!mid_ok && guard < 4000) begin
        if (inject && b == 4 && guard == 0) begin
          wr_byte = ~d;
          wr_stb = 1'b1;
        end
        step();
        mid_ok = last_tick && (mcnt == 8);
        guard++;
      end
      chk($sformatf("R1 R4 R8 frame bit %0d of byte %02h", b, d), txd, exp_bit(d, b));
      if (b == 9) chk("R7 done low in stop bit", tx_done, 0);
    end
    guard = 0;
    while (!tx_done && guard < 4000) begin
      step();
      guard++;
    end
    chk("R7 done rises on stop-ending rollover", tx_done && last_roll, 1);
    for (int i = 0; i < 5; i++) step();
    chk("R7 done holds", tx_done, 1);
    if (inject) begin
      second = 0;
      for (int i = 0; i < 1200; i++) begin
        step();
        if (!txd) second = 1;
      end
      chk("R8 no second frame, R2 idle high", second, 0);
    end
    done_clr = 1'b1;
    step();
    chk("R7 done cleared", tx_done, 0);
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    #1;
    chk("R9 txd high in reset", txd, 1);
    chk("R9 done low in reset", tx_done, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 20; i++) step();
    chk("R2 idle high after reset", txd, 1);
    for (int m = 0; m < 2; m++) begin
      no_halve = (m == 0);
      send_frame(8'h00, 0, 3);
      send_frame(8'hFF, 0, 1);
      send_frame(8'h01, 1, 7);
      send_frame(8'h80, 0, 0);
      for (int k = 0; k < 6; k++)
        send_frame(8'($urandom), ($urandom % 3 == 0), $urandom % 40);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(20 * 190000);
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule